// File: doc/BRIEF.md
# Multi-Mode DAC Word Distributor

This block sits between a 10-bit parallel pixel bus and four DAC output registers. Two strobe lines come in with no fixed phase to the system clock. A faster system clock samples them, and edges are found from those samples. Each captured word is sorted into a per-DAC holding slot. Three capture schemes are available. The sequential scheme uses one strobe as the clock and the other as a "DAC0 word" tag. The quadrature scheme captures on both edges of both strobes. The luma/chroma scheme routes Y, Cr and Cb words to fixed DACs.

A group of words is committed to the DACs together when the word that opens the next group arrives. The committed values then pass through two more register stages to the outputs. An invert control complements incoming data. Each DAC has its own enable, and a disabled DAC drives zero. The strobes must stay stable for at least four system clocks between edges, and data and tag must be stable while an edge is being sampled.

Top module: `dac_demux_top`

## Requirements
- R1: After reset every DAC output is zero, the slot pointer is at DAC0, and words captured before the first group-opening word are discarded. That first opening word commits nothing.
- R2: Sequential scheme (all three mode controls low): a word is captured on each rising edge of `strobe1`. If `strobe0` is high at that edge, the word goes to the DAC0 slot. Each following word goes to the DAC1, DAC2 and DAC3 slots in turn, and any words after that overwrite the DAC3 slot.
- R3: When a group-opening word is captured, all four holding slots are committed to the DACs in the same cycle. A slot not written during a group keeps its earlier value.
- R4: Committed values reach the outputs two system clocks after the commit. In total, a strobe change applied between clock edges shows at the outputs on the fifth rising clock edge after it.
- R5: Quadrature scheme: a rising edge of `strobe0` while `strobe1` is low opens a group with the DAC0 word. The rising edge of `strobe1` fills DAC1, the falling edge of `strobe0` fills DAC2, and the falling edge of `strobe1` fills DAC3.
- R6: Luma/chroma scheme: words are captured on rising edges of `strobe1`. A word with `strobe0` high is Cr. It goes to DAC2 and opens a group that commits the previous Cr and Cb. The second word after Cr is Cb and goes to DAC0. Every other untagged word is Y and goes straight to DAC1's commit stage. DAC3 is never written.
- R7: If either `dual_edge` or `dual_clk` is set, the quadrature scheme is used and `yc_mode` is ignored. The luma/chroma scheme runs only when `yc_mode` is set and both dual controls are low.
- R8: When `invert` is high at capture, the bitwise complement of `din` is captured.
- R9: A DAC whose enable bit (`dac_en[i]` for DAC i) is low drives zero on the first clock edge after the bit is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the strobe rate |
| rst | input | 1 | Synchronous active-high reset |
| strobe0 | input | 1 | Asynchronous strobe: tag line or quadrature clock |
| strobe1 | input | 1 | Asynchronous strobe: main capture clock |
| din | input | 10 | Parallel data word |
| dual_edge | input | 1 | Capture on both edges (selects quadrature scheme) |
| dual_clk | input | 1 | Use both strobes as clocks (selects quadrature scheme) |
| yc_mode | input | 1 | Luma/chroma routing when both dual controls are low |
| invert | input | 1 | Complement data at capture |
| dac_en | input | 4 | Per-DAC enable, bit i for DAC i |
| dac0_q | output | 10 | DAC0 output register |
| dac1_q | output | 10 | DAC1 output register |
| dac2_q | output | 10 | DAC2 output register |
| dac3_q | output | 10 | DAC3 output register |

## Verification
A slot pointer that is off by one shows up as a word landing on the wrong DAC. This becomes visible at the next group commit, so it appears one group late and then recurs on every later group. A bad started flag either lets pre-opening junk reach the outputs or holds back the first commit. Wrong latency is caught by sampling the outputs on the fourth and fifth edges after a strobe edge. An error in enable or inversion is visible within one commit.

// File: rtl/dd_pkg.sv
package dd_pkg;

    localparam int NUM_DAC = 4;

    typedef enum logic [1:0] {
        CAP_SEQ  = 2'd0,
        CAP_QUAD = 2'd1,
        CAP_YC   = 2'd2
    } cap_mode_e;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } strobe_ev_t;

    function automatic cap_mode_e pick_mode(input logic dual_edge,
                                            input logic dual_clk,
                                            input logic yc_mode);
        if (dual_edge || dual_clk)
            return CAP_QUAD;
        else if (yc_mode)
            return CAP_YC;
        else
            return CAP_SEQ;
    endfunction

endpackage

// File: rtl/dd_strobe_sync.sv
module dd_strobe_sync
    import dd_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       async_in,
    output strobe_ev_t ev
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    always_comb begin
        ev.level = chain_q[STAGES-1];
        ev.rise  = chain_q[STAGES-1] & ~prev_q;
        ev.fall  = ~chain_q[STAGES-1] & prev_q;
    end

endmodule

// File: rtl/dd_collect.sv
module dd_collect
    import dd_pkg::*;
#(
    parameter int DW = 10
) (
    input  logic                       clk,
    input  logic                       rst,
    input  cap_mode_e                  mode,
    input  strobe_ev_t                 ev0,
    input  strobe_ev_t                 ev1,
    input  logic [DW-1:0]              word,
    output logic [NUM_DAC-1:0][DW-1:0] staged_q
);

    localparam int PTR_W = $clog2(NUM_DAC);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_DAC - 1);

    logic [NUM_DAC-1:0][DW-1:0] hold_q;
    logic [PTR_W-1:0]           ptr_q;
    logic                       started_q;
    logic                       open_grp;

    always_comb begin
        unique case (mode)
            CAP_QUAD: open_grp = ev0.rise & ~ev1.level;
            default:  open_grp = ev1.rise & ev0.level;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q    <= '0;
            staged_q  <= '0;
            ptr_q     <= '0;
            started_q <= 1'b0;
        end else begin
            unique case (mode)
                CAP_SEQ: begin
                    if (open_grp) begin
                        if (started_q) staged_q <= hold_q;
                        hold_q[0] <= word;
                        ptr_q     <= PTR_W'(1);
                        started_q <= 1'b1;
                    end else if (ev1.rise && started_q) begin
                        hold_q[ptr_q] <= word;
                        if (ptr_q != LAST) ptr_q <= ptr_q + 1'b1;
                    end
                end
                CAP_QUAD: begin
                    if (open_grp) begin
                        if (started_q) staged_q <= hold_q;
                        hold_q[0] <= word;
                        started_q <= 1'b1;
                    end
                    if (started_q) begin
                        if (ev1.rise) hold_q[1] <= word;
                        if (ev0.fall) hold_q[2] <= word;
                        if (ev1.fall) hold_q[3] <= word;
                    end
                end
                CAP_YC: begin
                    if (open_grp) begin
                        if (started_q) begin
                            staged_q[0] <= hold_q[0];
                            staged_q[2] <= hold_q[2];
                        end
                        hold_q[2] <= word;
                        ptr_q     <= PTR_W'(1);
                        started_q <= 1'b1;
                    end else if (ev1.rise && started_q) begin
                        if (ptr_q == PTR_W'(2)) hold_q[0]   <= word;
                        else                    staged_q[1] <= word;
                        if (ptr_q != LAST) ptr_q <= ptr_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R1: nothing reaches the commit stage before a group has been opened
    a_r1_quiet_until_start: assert property (@(posedge clk) disable iff (rst)
        !started_q |-> staged_q == '0);

    // R3: a group opening in the sequential or quadrature scheme commits every slot at once
    a_r3_group_commit: assert property (@(posedge clk) disable iff (rst)
        (open_grp && started_q && mode != CAP_YC) |=> staged_q == $past(hold_q));

    // R6: luma/chroma routing never writes DAC3
    a_r6_dac3_untouched: assert property (@(posedge clk) disable iff (rst)
        (mode == CAP_YC) |=> $stable(staged_q[3]));

endmodule

// File: rtl/dd_outpipe.sv
module dd_outpipe
    import dd_pkg::*;
#(
    parameter int DW = 10
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_DAC-1:0][DW-1:0] staged,
    input  logic [NUM_DAC-1:0]         en,
    output logic [NUM_DAC-1:0][DW-1:0] q
);

    logic [NUM_DAC-1:0][DW-1:0] mid_q;

    for (genvar i = 0; i < NUM_DAC; i++) begin : g_dac
        always_ff @(posedge clk) begin
            if (rst) begin
                mid_q[i] <= '0;
                q[i]     <= '0;
            end else begin
                mid_q[i] <= staged[i];
                q[i]     <= en[i] ? mid_q[i] : '0;
            end
        end

        // R9: disabled DAC drives zero on the next edge
        a_r9_off_zero: assert property (@(posedge clk) disable iff (rst)
            !en[i] |=> q[i] == '0);

        // R4: an enabled output shows the committed value two clocks later
        a_r4_two_cycle: assert property (@(posedge clk) disable iff (rst)
            $past(en[i]) |-> q[i] == $past(staged[i], 2));
    end

endmodule

// File: rtl/dac_demux_top.sv
module dac_demux_top
    import dd_pkg::*;
#(
    parameter int DW        = 10,
    parameter int SYNC_LEN  = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe0,
    input  logic          strobe1,
    input  logic [DW-1:0] din,
    input  logic          dual_edge,
    input  logic          dual_clk,
    input  logic          yc_mode,
    input  logic          invert,
    input  logic [3:0]    dac_en,
    output logic [DW-1:0] dac0_q,
    output logic [DW-1:0] dac1_q,
    output logic [DW-1:0] dac2_q,
    output logic [DW-1:0] dac3_q
);

    logic [1:0]                 strobes;
    strobe_ev_t                 ev [2];
    cap_mode_e                  mode;
    logic [DW-1:0]              word;
    logic [NUM_DAC-1:0][DW-1:0] staged;
    logic [NUM_DAC-1:0][DW-1:0] outs;

    assign strobes = {strobe1, strobe0};
    assign mode    = pick_mode(dual_edge, dual_clk, yc_mode);
    assign word    = invert ? ~din : din;

    for (genvar s = 0; s < 2; s++) begin : g_sync
        dd_strobe_sync #(.STAGES(SYNC_LEN)) i_sync (
            .clk      (clk),
            .rst      (rst),
            .async_in (strobes[s]),
            .ev       (ev[s])
        );
    end

    dd_collect #(.DW(DW)) i_collect (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .ev0      (ev[0]),
        .ev1      (ev[1]),
        .word     (word),
        .staged_q (staged)
    );

    dd_outpipe #(.DW(DW)) i_outpipe (
        .clk    (clk),
        .rst    (rst),
        .staged (staged),
        .en     (dac_en),
        .q      (outs)
    );

    assign dac0_q = outs[0];
    assign dac1_q = outs[1];
    assign dac2_q = outs[2];
    assign dac3_q = outs[3];

    // R7: either dual control forces the quadrature scheme
    a_r7_dual_overrides: assert property (@(posedge clk) disable iff (rst)
        (dual_edge || dual_clk) |-> mode == CAP_QUAD);

endmodule

// File: tb/test_dac_demux_top.sv
`timescale 1ns/1ps
module test_dac_demux_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strobe0 = 1'b0, strobe1 = 1'b0;
    logic [9:0] din = '0;
    logic       dual_edge = 0, dual_clk = 0, yc_mode = 0, invert = 0;
    logic [3:0] dac_en = 4'hF;
    logic [9:0] dac0_q, dac1_q, dac2_q, dac3_q;
    logic [9:0] act [4];

    int n_tests = 0, n_fail = 0;

    // bench model
    logic [9:0] m_hold [4];
    logic [9:0] m_stg  [4];
    logic       m_started;
    int         m_ptr;
    int         md; // 0 sequential, 1 quadrature, 2 luma/chroma

    always #2.5 clk = ~clk;

    dac_demux_top i_dac_demux_top (
        .clk(clk), .rst(rst), .strobe0(strobe0), .strobe1(strobe1), .din(din),
        .dual_edge(dual_edge), .dual_clk(dual_clk), .yc_mode(yc_mode),
        .invert(invert), .dac_en(dac_en),
        .dac0_q(dac0_q), .dac1_q(dac1_q), .dac2_q(dac2_q), .dac3_q(dac3_q)
    );

    assign act[0] = dac0_q;
    assign act[1] = dac1_q;
    assign act[2] = dac2_q;
    assign act[3] = dac3_q;

    function automatic logic [9:0] exp_out(int i);
        return dac_en[i] ? m_stg[i] : 10'd0;
    endfunction

    function automatic logic [9:0] cap(logic [9:0] d);
        return invert ? ~d : d;
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_one(string tag, int i, logic [9:0] e);
        n_tests++;
        if (act[i] !== e) begin
            n_fail++;
            $display("FAIL %s dac%0d: actual %h expected %h", tag, i, act[i], e);
        end
    endtask

    task automatic check_all(string tag);
        for (int i = 0; i < 4; i++) check_one(tag, i, exp_out(i));
    endtask

    task automatic do_reset();
        rst = 1'b1; strobe0 = 0; strobe1 = 0;
        tick(3);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) begin m_hold[i] = '0; m_stg[i] = '0; end
        m_started = 0; m_ptr = 0;
        tick(2);
    endtask

    task automatic model_s1rise(logic [9:0] w, logic flag);
        if (md == 0) begin
            if (flag) begin
                if (m_started) for (int i = 0; i < 4; i++) m_stg[i] = m_hold[i];
                m_hold[0] = w; m_ptr = 1; m_started = 1;
            end else if (m_started) begin
                m_hold[m_ptr] = w;
                if (m_ptr != 3) m_ptr++;
            end
        end else begin
            if (flag) begin
                if (m_started) begin m_stg[0] = m_hold[0]; m_stg[2] = m_hold[2]; end
                m_hold[2] = w; m_ptr = 1; m_started = 1;
            end else if (m_started) begin
                if (m_ptr == 2) m_hold[0] = w; else m_stg[1] = w;
                if (m_ptr != 3) m_ptr++;
            end
        end
    endtask

    // one word on a strobe1 rising edge, strobe0 as tag
    task automatic s1_word(logic [9:0] d, logic flag, bit timed);
        logic [9:0] old [4];
        din = d; strobe0 = flag;
        tick(2);
        for (int i = 0; i < 4; i++) old[i] = exp_out(i);
        strobe1 = 1'b1;
        model_s1rise(cap(d), flag);
        if (timed) begin
            tick(4);
            for (int i = 0; i < 4; i++) check_one("R4 fourth edge unchanged", i, old[i]);
            tick(1);
            check_all("R4 fifth edge updated");
            tick(3);
        end else begin
            tick(8);
        end
        strobe1 = 1'b0;
        tick(4);
    endtask

    task automatic quad_group(logic [9:0] d0, logic [9:0] d1, logic [9:0] d2, logic [9:0] d3);
        din = d0; strobe0 = 1'b1;
        if (m_started) for (int i = 0; i < 4; i++) m_stg[i] = m_hold[i];
        m_hold[0] = cap(d0); m_started = 1;
        tick(5);
        din = d1; strobe1 = 1'b1; m_hold[1] = cap(d1); tick(5);
        din = d2; strobe0 = 1'b0; m_hold[2] = cap(d2); tick(5);
        din = d3; strobe1 = 1'b0; m_hold[3] = cap(d3); tick(5);
    endtask

    initial begin
        #(200000 * 5);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        md = 0;
        do_reset();
        check_all("R1 reset zero");

        // R1: untagged words before the first opening word are ignored
        s1_word(10'h3AA, 0, 0);
        s1_word(10'h155, 0, 0);
        s1_word(10'h011, 1, 0);
        s1_word(10'h022, 0, 0);
        s1_word(10'h033, 0, 0);
        s1_word(10'h044, 0, 0);
        check_all("R1 no commit on first opening word");
        // R2 R3: next opening word commits the group in order
        s1_word(10'h101, 1, 0);
        check_all("R2 R3 sequential group commit");
        // R2: extra words overwrite DAC3 slot, R4 latency on commit
        s1_word(10'h202, 0, 0);
        s1_word(10'h203, 0, 0);
        s1_word(10'h204, 0, 0);
        s1_word(10'h205, 0, 0);
        s1_word(10'h206, 0, 0);
        s1_word(10'h2F0, 1, 1);
        check_all("R2 overflow into DAC3 slot");
        // R3: short group keeps earlier slot values
        s1_word(10'h0AB, 0, 0);
        s1_word(10'h0CD, 1, 0);
        check_all("R3 unwritten slots keep value");

        // random sequential groups
        for (int g = 0; g < 12; g++) begin
            int n = 1 + int'($urandom % 6);
            for (int k = 1; k < n; k++) s1_word(10'($urandom), 0, 0);
            s1_word(10'($urandom), 1, 0);
            check_all("R2 R3 random sequential group");
        end

        // R8: inversion at capture
        invert = 1;
        for (int k = 0; k < 4; k++) s1_word(10'h000 + 10'(k * 3), k == 0, 0);
        s1_word(10'h3FF, 1, 0);
        check_all("R8 inverted group");
        invert = 0;

        // R9: per-DAC enable
        dac_en = 4'b0101;
        tick(1);
        check_all("R9 disabled DACs zero");
        dac_en = 4'b1111;
        tick(3);
        check_all("R9 re-enabled DACs");

        // R5 R7: quadrature scheme, yc_mode must be ignored
        md = 1; dual_edge = 1; dual_clk = 1; yc_mode = 1;
        do_reset();
        quad_group(10'h111, 10'h122, 10'h133, 10'h144);
        check_all("R5 first quadrature group not committed");
        quad_group(10'h211, 10'h222, 10'h233, 10'h244);
        check_all("R5 R7 quadrature commit");
        for (int g = 0; g < 10; g++) begin
            quad_group(10'($urandom), 10'($urandom), 10'($urandom), 10'($urandom));
            check_all("R5 random quadrature group");
        end
        // R7: only one dual control set still selects quadrature
        dual_edge = 0;
        quad_group(10'h3C1, 10'h3C2, 10'h3C3, 10'h3C4);
        quad_group(10'h001, 10'h002, 10'h003, 10'h004);
        check_all("R7 single dual bit selects quadrature");

        // R6: luma/chroma routing
        md = 2; dual_clk = 0; dual_edge = 0; yc_mode = 1;
        do_reset();
        for (int g = 0; g < 8; g++) begin
            s1_word(10'($urandom), 1, 0);   // Cr
            s1_word(10'($urandom), 0, 0);   // Y
            check_all("R6 luma to DAC1");
            s1_word(10'($urandom), 0, 0);   // Cb
            s1_word(10'($urandom), 0, 0);   // Y
            check_all("R6 chroma routing");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule